// File: doc/BRIEF.md
# Colour Lookup Table Register Front End

This block sits between a register bus and a 256-entry RGB colour lookup table. Each table entry holds three colour components. Software programs the table through three registers. An index register holds separate read and write positions. A data register streams components into or out of the table. A DAC control register selects whether components are 6 or 8 bits wide. Each position pairs an entry index with a component sub-counter. The sub-counter steps through red, green and blue, and after the third component the entry index moves on.

A write to the data register carries a whole colour word. The word is lane-aligned by its byte offset, byte-reversed and shifted down one byte. The three low bytes of the result are then issued to the table as three component writes on consecutive cycles, lowest byte first. A read of the data register returns one component from the read position and advances that position. The table itself is outside the block. The block drives its write port and its combinational read port.

Top module: `palx_port`

## Requirements
- R1: After reset, both positions are entry 0 at component 0, the DAC control value is 0 (6-bit mode), no table write is issued and `reg_rdata` is 0.
- R2: A 32-bit write (`reg_full`=1) to the index register (`reg_sel`=0) loads the read index from bits 23:16 and the write index from bits 7:0, and resets both component sub-counters to 0.
- R3: A single-byte write to the index register at byte offset 0 loads only the write index from `reg_wdata[7:0]`. At offsets 1 to 3 it loads only the read index. Only the loaded position's sub-counter is reset.
- R4: A read of any register updates `reg_rdata` on the next clock edge, and the value then holds until the next read. The index register reads as read index in bits 23:16 and write index in bits 7:0, with all other bits 0.
- R5: A write to the data register (`reg_sel`=1) computes a word. The value is taken right-justified (one byte when `reg_full`=0) and shifted left by 8 times `reg_off`. The result is byte-reversed and shifted right by 8 bits. Its bytes 0, 1 and 2 are written to components 0, 1 and 2 of the write entry, in the three cycles after the write. A word 0x00RRGGBB therefore writes RR, GG, BB.
- R6: Every component write advances the write position. After component 2 the index increments, and 255 wraps to 0.
- R7: A read of the data register returns the component at the read position in bits 7:0, with the upper bits 0. It then advances the read position in the same way as R6.
- R8: The DAC control register (`reg_sel`=2) stores written bytes. A byte write changes only its own lane. Bits 12:10 always read as 0. Bit 8 set selects 8-bit components, and clear selects 6-bit components.
- R9: In 6-bit mode, written components keep only their low 6 bits, and data reads return the low 6 bits of the stored component, zero-extended.
- R10: The component width used for a data write is fixed by the mode in effect when the write is accepted. A mode change during the following three write cycles does not alter it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_sel | input | 2 | 0 index, 1 data, 2 DAC control, 3 unused |
| reg_off | input | 2 | Byte offset of a single-byte access |
| reg_full | input | 1 | 1: 32-bit access, 0: single byte in bits 7:0 |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after `reg_rd` |
| pal_we | output | 1 | Table component write enable |
| pal_waddr | output | IDX_W | Table write entry |
| pal_wcomp | output | $clog2(COMP_N) | Table write component |
| pal_wdata | output | CW | Table write component value |
| pal_raddr | output | IDX_W | Table read entry |
| pal_rcomp | output | $clog2(COMP_N) | Table read component |
| pal_rdata | input | CW | Table read data, combinational from `pal_raddr`/`pal_rcomp` |

## Verification
A data write runs for three cycles, so a DAC control write can land in the same cycle as the second component write of a running burst. The bench provokes this by issuing a mode write on the cycle right after a data write, in both directions: 8-bit to 6-bit, and 6-bit to 8-bit. It then judges the result from the stored table entry. All three components must carry the width of the mode in force when the data write was accepted.

// File: rtl/palx_pkg.sv
package palx_pkg;

   typedef enum logic [1:0] {
      SEL_INDEX  = 2'd0,
      SEL_DATA   = 2'd1,
      SEL_DACCTL = 2'd2,
      SEL_NONE   = 2'd3
   } palx_sel_e;

   // lane-align by byte offset, reverse the four bytes, drop the low byte
   function automatic logic [31:0] palx_reorder(input logic [31:0] w,
                                                input logic [1:0]  off);
      logic [31:0] s;
      s = w << {off, 3'b000};
      return {s[7:0], s[15:8], s[23:16], s[31:24]} >> 8;
   endfunction

endpackage

// File: rtl/palx_ptr.sv
// entry index plus component sub-counter, used for both read and write side
module palx_ptr #(
   parameter int IDX_W  = 8,
   parameter int COMP_N = 3,
   localparam int CSEL_W = $clog2(COMP_N)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [IDX_W-1:0]  load_idx,
   input  logic              step,
   output logic [IDX_W-1:0]  idx,
   output logic [CSEL_W-1:0] comp
);
   localparam logic [CSEL_W-1:0] LAST = CSEL_W'(COMP_N - 1);

   generate
      if (COMP_N < 2) begin : g_bad_comp
         $error("palx_ptr: COMP_N must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx  <= '0;
         comp <= '0;
      end else if (load) begin
         idx  <= load_idx;
         comp <= '0;
      end else if (step) begin
         if (comp == LAST) begin
            comp <= '0;
            idx  <= idx + IDX_W'(1);
         end else begin
            comp <= comp + CSEL_W'(1);
         end
      end
   end
endmodule

// File: rtl/palx_burst.sv
// captures one packed colour word and emits it one component per cycle
module palx_burst #(
   parameter int CW       = 8,
   parameter int COMP_N   = 3,
   parameter int NARROW_W = 6,
   localparam int PACK_W  = CW * COMP_N
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [PACK_W-1:0] word,
   input  logic              narrow,
   output logic              active,
   output logic [CW-1:0]     comp_out
);
   localparam int CNT_W = $clog2(COMP_N + 1);

   logic [PACK_W-1:0] trunc;
   logic [PACK_W-1:0] shreg;
   logic [CNT_W-1:0]  cnt;

   generate
      for (genvar g = 0; g < COMP_N; g++) begin : g_lane
         if (NARROW_W < CW) begin : g_cut
            assign trunc[g*CW +: CW] = narrow ? CW'(word[g*CW +: NARROW_W])
                                              : word[g*CW +: CW];
         end else begin : g_pass
            assign trunc[g*CW +: CW] = word[g*CW +: CW];
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg <= '0;
         cnt   <= '0;
      end else if (start) begin
         shreg <= trunc;
         cnt   <= CNT_W'(COMP_N);
      end else if (cnt != '0) begin
         shreg <= shreg >> CW;
         cnt   <= cnt - CNT_W'(1);
      end
   end

   assign active   = (cnt != '0);
   assign comp_out = shreg[CW-1:0];
endmodule

// File: rtl/palx_dacreg.sv
// byte-lane writable control word with forced-zero bits
module palx_dacreg #(
   parameter logic [31:0] ZERO_MASK = 32'h0000_1C00
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr,
   input  logic        full,
   input  logic [1:0]  off,
   input  logic [31:0] wdata,
   output logic [31:0] value
);
   logic [3:0]  lane_en;
   logic [31:0] lane_d;
   logic [31:0] bmask;

   assign lane_en = full ? 4'hF : (4'b0001 << off);
   assign lane_d  = full ? wdata : {4{wdata[7:0]}};

   generate
      for (genvar g = 0; g < 4; g++) begin : g_mask
         assign bmask[g*8 +: 8] = {8{lane_en[g]}};
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  value <= '0;
      else if (wr) value <= ((value & ~bmask) | (lane_d & bmask)) & ~ZERO_MASK;
   end
endmodule

// File: rtl/palx_port.sv
module palx_port #(
   parameter int          IDX_W     = 8,
   parameter int          CW        = 8,
   parameter int          COMP_N    = 3,
   parameter int          NARROW_W  = 6,
   parameter int          DAC8_POS  = 8,
   parameter logic [31:0] ZERO_MASK = 32'h0000_1C00
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      reg_wr,
   input  logic                      reg_rd,
   input  logic [1:0]                reg_sel,
   input  logic [1:0]                reg_off,
   input  logic                      reg_full,
   input  logic [31:0]               reg_wdata,
   output logic [31:0]               reg_rdata,
   output logic                      pal_we,
   output logic [IDX_W-1:0]          pal_waddr,
   output logic [$clog2(COMP_N)-1:0] pal_wcomp,
   output logic [CW-1:0]             pal_wdata,
   output logic [IDX_W-1:0]          pal_raddr,
   output logic [$clog2(COMP_N)-1:0] pal_rcomp,
   input  logic [CW-1:0]             pal_rdata
);
   import palx_pkg::*;

   localparam int PACK_W = CW * COMP_N;

   generate
      if (IDX_W > 8) begin : g_bad_idx
         $error("palx_port: IDX_W must fit an 8-bit index field");
      end
      if (PACK_W > 32) begin : g_bad_pack
         $error("palx_port: COMP_N*CW must fit the 32-bit data word");
      end
      if (NARROW_W > CW) begin : g_bad_narrow
         $error("palx_port: NARROW_W must not exceed CW");
      end
      if (DAC8_POS > 31) begin : g_bad_pos
         $error("palx_port: DAC8_POS out of range");
      end
   endgenerate

   palx_sel_e sel;
   assign sel = palx_sel_e'(reg_sel);

   // index register decode
   logic             idx_wr, w_load, r_load;
   logic [IDX_W-1:0] r_load_val;
   assign idx_wr     = reg_wr && (sel == SEL_INDEX);
   assign w_load     = idx_wr && (reg_full || (reg_off == 2'd0));
   assign r_load     = idx_wr && (reg_full || (reg_off != 2'd0));
   assign r_load_val = reg_full ? reg_wdata[16 +: IDX_W] : reg_wdata[IDX_W-1:0];

   // DAC control
   logic [31:0] dac_value;
   logic        narrow;
   palx_dacreg #(.ZERO_MASK(ZERO_MASK)) u_dac (
      .clk   (clk),
      .rst_n (rst_n),
      .wr    (reg_wr && (sel == SEL_DACCTL)),
      .full  (reg_full),
      .off   (reg_off),
      .wdata (reg_wdata),
      .value (dac_value)
   );
   assign narrow = !dac_value[DAC8_POS];

   // data write: reorder then stream out one component per cycle
   logic [PACK_W-1:0] pack;
   logic              burst_on;
   assign pack = PACK_W'(palx_reorder(reg_full ? reg_wdata : {24'h0, reg_wdata[7:0]},
                                      reg_full ? 2'd0 : reg_off));

   palx_burst #(.CW(CW), .COMP_N(COMP_N), .NARROW_W(NARROW_W)) u_burst (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (reg_wr && (sel == SEL_DATA)),
      .word     (pack),
      .narrow   (narrow),
      .active   (burst_on),
      .comp_out (pal_wdata)
   );

   palx_ptr #(.IDX_W(IDX_W), .COMP_N(COMP_N)) u_wptr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (w_load),
      .load_idx (reg_wdata[IDX_W-1:0]),
      .step     (burst_on),
      .idx      (pal_waddr),
      .comp     (pal_wcomp)
   );

   palx_ptr #(.IDX_W(IDX_W), .COMP_N(COMP_N)) u_rptr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (r_load),
      .load_idx (r_load_val),
      .step     (reg_rd && (sel == SEL_DATA)),
      .idx      (pal_raddr),
      .comp     (pal_rcomp)
   );

   assign pal_we = burst_on;

   // read data
   logic [CW-1:0] rd_comp;
   assign rd_comp = narrow ? CW'(pal_rdata[NARROW_W-1:0]) : pal_rdata;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         reg_rdata <= '0;
      end else if (reg_rd) begin
         case (sel)
            SEL_INDEX:  reg_rdata <= {8'h00, 8'(pal_raddr), 8'h00, 8'(pal_waddr)};
            SEL_DATA:   reg_rdata <= 32'(rd_comp);
            SEL_DACCTL: reg_rdata <= dac_value;
            default:    reg_rdata <= '0;
         endcase
      end
   end
endmodule

// File: rtl/palx_port_chk.sv
module palx_port_chk #(
   parameter int          IDX_W     = 8,
   parameter int          COMP_N    = 3,
   parameter logic [31:0] ZERO_MASK = 32'h0000_1C00
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic                      reg_wr,
   input logic                      reg_rd,
   input logic [1:0]                reg_sel,
   input logic [1:0]                reg_off,
   input logic                      reg_full,
   input logic [31:0]               reg_wdata,
   input logic [31:0]               reg_rdata,
   input logic                      pal_we,
   input logic [IDX_W-1:0]          pal_waddr,
   input logic [$clog2(COMP_N)-1:0] pal_wcomp,
   input logic [IDX_W-1:0]          pal_raddr,
   input logic [$clog2(COMP_N)-1:0] pal_rcomp
);
   localparam int CSEL_W = $clog2(COMP_N);
   localparam logic [CSEL_W-1:0] LAST = CSEL_W'(COMP_N - 1);

   logic idx_wr, data_wr, data_rd;
   assign idx_wr  = reg_wr && (reg_sel == 2'd0);
   assign data_wr = reg_wr && (reg_sel == 2'd1);
   assign data_rd = reg_rd && (reg_sel == 2'd1);

   a_r5_burst_starts: assert property (@(posedge clk) disable iff (!rst_n)
      data_wr |=> pal_we);

   a_r6_write_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (pal_we && pal_wcomp == LAST && !idx_wr)
      |=> (pal_waddr == $past(pal_waddr) + IDX_W'(1)) && (pal_wcomp == '0));

   a_r7_read_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (data_rd && pal_rcomp == LAST && !idx_wr)
      |=> (pal_raddr == $past(pal_raddr) + IDX_W'(1)) && (pal_rcomp == '0));

   a_r2_full_load: assert property (@(posedge clk) disable iff (!rst_n)
      (idx_wr && reg_full)
      |=> (pal_waddr == $past(reg_wdata[IDX_W-1:0])) &&
          (pal_raddr == $past(reg_wdata[16 +: IDX_W])) &&
          (pal_wcomp == '0) && (pal_rcomp == '0));

   a_r3_byte0_keeps_read: assert property (@(posedge clk) disable iff (!rst_n)
      (idx_wr && !reg_full && reg_off == 2'd0 && !data_rd)
      |=> $stable(pal_raddr) && $stable(pal_rcomp));

   a_r8_zero_bits: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rd && reg_sel == 2'd2) |=> ((reg_rdata & ZERO_MASK) == 32'h0));

   always_ff @(posedge clk) begin
      if (rst_n) begin
         a_r6_comp_range: assert (pal_wcomp <= LAST && pal_rcomp <= LAST);
      end
   end
endmodule

bind palx_port palx_port_chk #(
   .IDX_W(IDX_W), .COMP_N(COMP_N), .ZERO_MASK(ZERO_MASK)
) u_chk (
   .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
   .reg_sel(reg_sel), .reg_off(reg_off), .reg_full(reg_full),
   .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pal_we(pal_we),
   .pal_waddr(pal_waddr), .pal_wcomp(pal_wcomp),
   .pal_raddr(pal_raddr), .pal_rcomp(pal_rcomp)
);

// File: tb/tb_palx_port.sv
module tb_palx_port;
   localparam int CLK_P = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0, reg_rd = 1'b0, reg_full = 1'b0;
   logic [1:0]  reg_sel = 2'd0, reg_off = 2'd0;
   logic [31:0] reg_wdata = 32'h0;
   logic [31:0] reg_rdata;
   logic        pal_we;
   logic [7:0]  pal_waddr, pal_raddr, pal_wdata, pal_rdata;
   logic [1:0]  pal_wcomp, pal_rcomp;

   int checks = 0, errors = 0;
   bit done = 1'b0;

   logic [7:0] ram [0:255][0:3];

   always #(CLK_P/2) clk = ~clk;

   always @(posedge clk) if (pal_we) ram[pal_waddr][pal_wcomp] <= pal_wdata;
   assign pal_rdata = ram[pal_raddr][pal_rcomp];

   palx_port dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_sel(reg_sel), .reg_off(reg_off), .reg_full(reg_full),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pal_we(pal_we),
      .pal_waddr(pal_waddr), .pal_wcomp(pal_wcomp), .pal_wdata(pal_wdata),
      .pal_raddr(pal_raddr), .pal_rcomp(pal_rcomp), .pal_rdata(pal_rdata)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] sel, input logic [1:0] off,
                     input logic full, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_sel = sel; reg_off = off; reg_full = full; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [1:0] sel, output logic [31:0] d);
      @(negedge clk);
      reg_rd = 1'b1; reg_sel = sel; reg_off = 2'd0; reg_full = 1'b1;
      @(negedge clk);
      reg_rd = 1'b0;
      d = reg_rdata;
   endtask

   task automatic chk_entry(input string req, input int e,
                            input logic [7:0] c0, input logic [7:0] c1, input logic [7:0] c2);
      chk(req, {8'h0, ram[e][0], ram[e][1], ram[e][2]}, {8'h0, c0, c1, c2});
   endtask

   task automatic t_reset;
      logic [31:0] v;
      chk("R1 rdata", reg_rdata, 32'h0);
      chk("R1 pal_we", 32'(pal_we), 32'h0);
      rd(2'd0, v); chk("R1 index", v, 32'h0);
      rd(2'd2, v); chk("R1 dacctl", v, 32'h0);
   endtask

   task automatic t_index;
      logic [31:0] v;
      wr(2'd0, 2'd0, 1'b1, 32'hFFAB_EECD);
      rd(2'd0, v); chk("R2 R4 full index load", v, 32'h00AB_00CD);
      wr(2'd0, 2'd0, 1'b0, 32'h0000_0012);
      rd(2'd0, v); chk("R3 byte0 write index only", v, 32'h00AB_0012);
      wr(2'd0, 2'd2, 1'b0, 32'h0000_0034);
      rd(2'd0, v); chk("R3 byte2 read index only", v, 32'h0034_0012);
   endtask

   task automatic t_data_write;
      logic [31:0] v;
      wr(2'd2, 2'd0, 1'b1, 32'h0000_0100);
      wr(2'd0, 2'd0, 1'b1, 32'h0000_0005);
      wr(2'd1, 2'd0, 1'b1, 32'h00C3_A5F0);
      repeat (3) @(negedge clk);
      chk_entry("R5 word order", 5, 8'hC3, 8'hA5, 8'hF0);
      rd(2'd0, v); chk("R6 write index step", v, 32'h0000_0006);
      wr(2'd1, 2'd1, 1'b0, 32'h0000_0077);
      repeat (3) @(negedge clk);
      chk_entry("R5 byte at offset 1", 6, 8'h00, 8'h77, 8'h00);
      rd(2'd0, v); chk("R6 second step", v, 32'h0000_0007);
   endtask

   task automatic t_wrap;
      logic [31:0] v;
      wr(2'd0, 2'd0, 1'b1, 32'h0000_00FF);
      wr(2'd1, 2'd0, 1'b1, 32'h0001_0203);
      repeat (3) @(negedge clk);
      chk_entry("R6 last entry", 255, 8'h01, 8'h02, 8'h03);
      rd(2'd0, v); chk("R6 wrap to 0", v, 32'h0000_0000);
   endtask

   task automatic t_data_read;
      logic [31:0] v;
      logic [7:0] exp [6] = '{8'hC3, 8'hA5, 8'hF0, 8'h00, 8'h77, 8'h00};
      wr(2'd0, 2'd3, 1'b0, 32'h0000_0005);
      rd(2'd0, v); chk("R3 byte3 read index only", v, 32'h0005_0000);
      for (int i = 0; i < 6; i++) begin
         rd(2'd1, v); chk("R7 data read", v, 32'(exp[i]));
      end
      rd(2'd0, v); chk("R7 read index stepped", v, 32'h0007_0000);
   endtask

   task automatic t_dacctl;
      logic [31:0] v;
      wr(2'd2, 2'd0, 1'b1, 32'hFFFF_FFFF);
      rd(2'd2, v); chk("R8 forced zero bits", v, 32'hFFFF_E3FF);
      wr(2'd2, 2'd0, 1'b0, 32'h0000_0000);
      rd(2'd2, v); chk("R8 byte lane 0", v, 32'hFFFF_E300);
      wr(2'd2, 2'd1, 1'b0, 32'h0000_0000);
      rd(2'd2, v); chk("R8 byte lane 1", v, 32'hFFFF_0000);
   endtask

   task automatic t_narrow;
      logic [31:0] v;
      wr(2'd0, 2'd0, 1'b1, 32'h000B_000A);
      wr(2'd1, 2'd0, 1'b1, 32'h00FF_C081);
      repeat (3) @(negedge clk);
      chk_entry("R9 narrow write", 10, 8'h3F, 8'h00, 8'h01);
      wr(2'd2, 2'd0, 1'b1, 32'h0000_0100);
      wr(2'd0, 2'd0, 1'b0, 32'h0000_000B);
      wr(2'd1, 2'd0, 1'b1, 32'h00FF_80C5);
      repeat (3) @(negedge clk);
      chk_entry("R9 wide write", 11, 8'hFF, 8'h80, 8'hC5);
      wr(2'd2, 2'd1, 1'b0, 32'h0000_0000);
      rd(2'd1, v); chk("R9 narrow read c0", v, 32'h3F);
      rd(2'd1, v); chk("R9 narrow read c1", v, 32'h00);
      rd(2'd1, v); chk("R9 narrow read c2", v, 32'h05);
   endtask

   task automatic t_mode_race;
      wr(2'd2, 2'd0, 1'b1, 32'h0000_0100);
      wr(2'd0, 2'd0, 1'b0, 32'h0000_0014);
      wr(2'd1, 2'd0, 1'b1, 32'h00FE_DCBA);
      wr(2'd2, 2'd0, 1'b1, 32'h0000_0000);
      repeat (2) @(negedge clk);
      chk_entry("R10 wide kept", 20, 8'hFE, 8'hDC, 8'hBA);
      wr(2'd0, 2'd0, 1'b0, 32'h0000_0015);
      wr(2'd1, 2'd0, 1'b1, 32'h00FE_DCBA);
      wr(2'd2, 2'd0, 1'b1, 32'h0000_0100);
      repeat (2) @(negedge clk);
      chk_entry("R10 narrow kept", 21, 8'h3E, 8'h1C, 8'h3A);
   endtask

   initial begin
      for (int e = 0; e < 256; e++)
         for (int c = 0; c < 4; c++) ram[e][c] = 8'h00;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_index();
      t_data_write();
      t_wrap();
      t_data_read();
      t_dacctl();
      t_narrow();
      t_mode_race();
      if (!done) begin
         done = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      #(CLK_P * 100000);
      if (!done) begin
         done = 1'b1;
         checks++; errors++;
         $display("FAIL watchdog: actual hung expected done");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule